// File: doc/BRIEF.md
# Dithered Switching-Period Generator

This block divides a fast reference clock down to a buck-converter switching rate and marks the start of each switching period with a single reference-cycle pulse. With the dither strap low, every period has the same length, set by the ratio of reference rate to switching rate. With the strap high, the period length moves along a triangle around that nominal value. Each switching period steps the length up or down by a fixed count of reference cycles. The step size and swing are set so that the frequency window is at least 12% of nominal and one full up-and-down sweep repeats at the modulation rate.

The strap is treated as static. A change on it is adopted only at a period boundary, or while the generator is disabled, and the length always restarts from nominal. Dropping the enable stops all pulses and returns the counter and the triangle to their starting state, as a thermal shutdown would need. With the default parameters (96 MHz reference, 600 kHz switching, 25 kHz modulation, 12% spread), the nominal period is 160 cycles. The sweep is 24 periods long with a step of 2 cycles and a swing of ±12 cycles.

Top module: `ssc_clkgen`

## Requirements
- R1: With dither off, every period lasts exactly REF_HZ/SW_HZ reference cycles (160 by default).
- R2: `period_tick` is high for exactly one reference cycle per period, in the last cycle of that period.
- R3: With dither on, successive periods change by 2 cycles each, starting from nominal and rising: 160, 162, …, 172, 170, …, 148, 150, …, 158, then 160 again.
- R4: One dither sweep spans 24 periods whose lengths sum to 3840 reference cycles (40 µs, a 25 kHz modulation rate), so the mean period equals nominal.
- R5: With dither on, the longest period is 172 and the shortest is 148, a frequency span of at least 12% of nominal.
- R6: `period_len` shows the length of the period in progress, and it equals the measured spacing of the tick that ends that period.
- R7: While `en` is low, no tick occurs and `period_len` returns to nominal. After `en` rises again, the first period is nominal and the next dithered period is nominal plus one step.
- R8: A change on `ss_en` in mid-period leaves that period's length unchanged. From the next boundary on, the new mode applies and the period starts again at nominal.
- R9: After reset, `period_tick` is low and `period_len` is nominal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Generator enable; low halts and restarts the period sequence |
| ss_en | input | 1 | Static dither strap; high selects triangular period dithering |
| period_tick | output | 1 | One-cycle pulse in the last reference cycle of each period |
| period_len | output | LW (8 by default) | Length in reference cycles of the current period |

## Verification
The bench measures tick spacing over two full sweeps and compares it against a triangle it builds itself. An off-by-one turning point would show up as a repeated 172 or 148 or a sweep longer than 24 periods. A wrong step would break the 3840-cycle sweep sum. The bench flips the strap mid-period in both directions. A design that applied the change at once would cut the running period short, and one that kept its triangle phase would not restart at 160. It also disables the generator mid-sweep and re-enables it. Any tick while disabled, or a first dithered period other than 162 afterwards, shows that state was not cleared.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic {
    SWEEP_UP = 1'b0,
    SWEEP_DN = 1'b1
  } sweep_dir_t;
endpackage

// File: rtl/ssc_period_ctr.sv
module ssc_period_ctr #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [LW-1:0] len,
  output logic          tick
);
  logic [LW-1:0] cnt;

  assign tick = en && (cnt == len - LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + LW'(1);
  end

  AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < len); // R6

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == '0); // R7
endmodule

// File: rtl/ssc_tri_profile.sv
module ssc_tri_profile
  import ssc_pkg::*;
#(
  parameter int DEV  = 12,
  parameter int STEP = 2,
  parameter int LVW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           tick,
  input  logic           ss_req,
  output logic [LVW-1:0] lvl,
  output logic           ss_act
);
  localparam logic [LVW-1:0] MID  = LVW'(DEV);
  localparam logic [LVW-1:0] TOP  = LVW'(2 * DEV);
  localparam logic [LVW-1:0] STP  = LVW'(STEP);

  sweep_dir_t dir;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl    <= MID;
      dir    <= SWEEP_UP;
      ss_act <= 1'b0;
    end else if (!en) begin
      lvl    <= MID;
      dir    <= SWEEP_UP;
      ss_act <= ss_req;
    end else if (tick) begin
      ss_act <= ss_req;
      if (!ss_req || (ss_req != ss_act)) begin
        lvl <= MID;
        dir <= SWEEP_UP;
      end else if (dir == SWEEP_UP) begin
        lvl <= lvl + STP;
        if (lvl + STP == TOP) dir <= SWEEP_DN;
      end else begin
        lvl <= lvl - STP;
        if (lvl == STP) dir <= SWEEP_UP;
      end
    end
  end

  AST_LVL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= TOP); // R5

  AST_LVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(lvl)); // R8

  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && ss_act && ss_req) |=>
      ((lvl == $past(lvl) + STP) || (lvl == $past(lvl) - STP))); // R3

  AST_FIXED_MID: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_act |-> lvl == MID); // R1
endmodule

// File: rtl/ssc_clkgen.sv
module ssc_clkgen #(
  parameter int REF_HZ     = 96_000_000,
  parameter int SW_HZ      = 600_000,
  parameter int MOD_HZ     = 25_000,
  parameter int SPREAD_PCT = 12,
  localparam int NOM       = REF_HZ / SW_HZ,
  localparam int SWEEP_N   = SW_HZ / MOD_HZ,
  localparam int QTR       = SWEEP_N / 4,
  localparam int DEV_MIN   = (NOM * SPREAD_PCT + 199) / 200,
  localparam int STEP      = (DEV_MIN + QTR - 1) / QTR,
  localparam int DEV       = STEP * QTR,
  localparam int LW        = $clog2(NOM + DEV + 1),
  localparam int LVW       = $clog2(2 * DEV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ss_en,
  output logic          period_tick,
  output logic [LW-1:0] period_len
);
  logic [LVW-1:0] lvl;
  logic           ss_act;

  assign period_len = LW'(NOM - DEV) + LW'(lvl);

  ssc_period_ctr #(.LW(LW)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .len  (period_len),
    .tick (period_tick)
  );

  ssc_tri_profile #(.DEV(DEV), .STEP(STEP), .LVW(LVW)) u_prof (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .tick  (period_tick),
    .ss_req(ss_en),
    .lvl   (lvl),
    .ss_act(ss_act)
  );

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick |=> !period_tick); // R2

  AST_OFF_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> period_len == LW'(NOM)); // R7

  AST_LEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !period_tick) |=> $stable(period_len)); // R6
endmodule

// File: tb/sim_ssc_clkgen.sv
module sim_ssc_clkgen;
  localparam int CLK_NS = 10;
  localparam int NOM_B  = 160;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       ss_en = 1'b0;
  logic       period_tick;
  logic [7:0] period_len;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #(CLK_NS/2) clk = ~clk;

  ssc_clkgen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .ss_en(ss_en),
    .period_tick(period_tick), .period_len(period_len)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // expected dither offset of period k after a restart (k=0 is nominal)
  function automatic int tri_ofs(input int k);
    int p;
    p = k % 24;
    if (p <= 6)       return 2 * p;
    else if (p <= 18) return 24 - 2 * p;
    else              return 2 * p - 48;
  endfunction

  // counts negedges up to and including the next tick
  task automatic measure(output int n, output int len_at);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!period_tick && n < 1000);
    len_at = int'(period_len);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R9 tick", int'(period_tick), 0);
    chk("R9 len", int'(period_len), NOM_B);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_fixed;
    int n, l;
    en = 1'b1;
    measure(n, l);
    for (int i = 0; i < 5; i++) begin
      measure(n, l);
      chk("R1 interval", n, NOM_B);
      chk("R6 len", l, n);
    end
    @(negedge clk);
    chk("R2 tick width", int'(period_tick), 0);
  endtask

  task automatic t_spread;
    int n, l, sum, mn, mx;
    real win;
    en = 1'b0;
    @(negedge clk);
    ss_en = 1'b1;
    @(negedge clk);
    en = 1'b1;
    measure(n, l);
    chk("R7 first len", l, NOM_B);
    sum = 0; mn = 1000; mx = 0;
    for (int k = 1; k <= 48; k++) begin
      measure(n, l);
      chk("R3 interval", n, NOM_B + tri_ofs(k));
      chk("R6 len", l, n);
      if (k <= 24) sum += n;
      if (n < mn) mn = n;
      if (n > mx) mx = n;
    end
    chk("R4 sweep sum", sum, 3840);
    chk("R5 max", mx, 172);
    chk("R5 min", mn, 148);
    win = (1.0 / mn - 1.0 / mx) * NOM_B;
    chk("R5 window>=12%", (win >= 0.12) ? 1 : 0, 1);
  endtask

  task automatic t_disable;
    int n, l, seen;
    en = 1'b0;
    seen = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (period_tick) seen++;
    end
    chk("R7 no tick while off", seen, 0);
    chk("R7 len off", int'(period_len), NOM_B);
    en = 1'b1;
    measure(n, l);
    chk("R7 restart len", l, NOM_B);
    measure(n, l);
    chk("R7 first step", n, NOM_B + 2);
  endtask

  task automatic t_toggle;
    int n, l;
    // now at start of period 2 (expected 164)
    repeat (50) @(negedge clk);
    ss_en = 1'b0;
    measure(n, l);
    chk("R8 off rest of period", n, 164 - 50);
    measure(n, l);
    chk("R8 off next", n, NOM_B);
    measure(n, l);
    chk("R1 off steady", n, NOM_B);
    repeat (30) @(negedge clk);
    ss_en = 1'b1;
    measure(n, l);
    chk("R8 on rest of period", n, NOM_B - 30);
    measure(n, l);
    chk("R8 on restart nominal", n, NOM_B);
    measure(n, l);
    chk("R3 after on", n, NOM_B + 2);
  endtask

  initial begin
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fixed();
    t_spread();
    t_disable();
    t_toggle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule